// File: doc/BRIEF.md
# Mark-Space Pulse Train Generator

This block plays back a short table of durations as a single digital pulse train, the way a remote-control transmitter builds its bursts. Entries take turns: the first drives the pulse output high (a mark), the next drives it low (a space), and so on. Each entry counts pulses of an external timebase enable, which is normally a 1 MHz strobe. A zero entry ends one pass through the table. A pass can be played a set number of times, or repeated until it is cancelled. While a mark plays, a carrier output toggles at a programmable period and duty. During a space or while idle, the carrier is held low.

Software, or a loader, fills the table through a valid/ready write port and then pulses `start` with a repeat count. A transfer happens in each cycle where `wr_valid` and `wr_ready` are both high. The block lowers `wr_ready` for the whole of a playback, so a writer must hold its word and address until the playback ends. Nothing else stalls the port. A write in the same cycle as `start` is not seen by that start. The last table slot is always treated as zero, so every table has a terminator. `cancel` lets the pass that is playing finish, and then playback stops. A `start` during playback abandons the current pass and begins again from the first entry.

Top module: `pulse_seq_top`

## Requirements
- R1: A table write takes effect in the cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high exactly when `busy` is low. A write to slot DEPTH-1 is dropped, and that slot always reads as zero.
- R2: Every pass begins with entry 0. Entries at even indices hold `pulse_out` high and entries at odd indices hold it low. An entry of value N lasts N `tick_en` pulses, so with `tick_en` held high it lasts exactly N clock cycles. `pulse_out` is low while idle.
- R3: The first zero entry at index K ends the pass. If K is odd, entry K-1 (a mark) is also dropped, so the pass always ends after a space.
- R4: The `reps` value sampled at `start` gives the number of passes: 1 plays once, N plays N times, and 0 repeats with no end. Each new pass starts in the cycle right after the previous pass's last space, with no idle cycle between them.
- R5: `cancel` during playback sets the number of remaining passes to one, so the pass in progress completes and then playback stops. `cancel` while idle has no effect on a later playback.
- R6: During a mark, `carrier_out` is high in the cycles where a free-running counter, which steps from 0 to `car_period` and then wraps, is below `car_compare`. A compare value of 0 keeps the carrier off. A compare value above `car_period` keeps it on for the whole mark. During a space and while idle, `carrier_out` is low.
- R7: `busy` rises in the cycle after `start` and falls after the final space of the final pass. If the effective end index is 0 (first entry zero, or a single mark only), `start` leaves `busy` low.
- R8: `edge_stb` is high for exactly one cycle at the first cycle of every entry played, including the first mark and each restart. A pass therefore produces as many strobes as its effective end index.
- R9: `start` during playback abandons the current pass and replays from entry 0, using the `reps` value presented with the new `start`.
- R10: While `tick_en` is low the running entry does not advance, so `pulse_out` holds its level and `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase enable; one pulse per duration tick |
| wr_valid | input | 1 | Table write request |
| wr_ready | output | 1 | Table can accept a write (idle) |
| wr_addr | input | AW | Table slot to write |
| wr_data | input | DW | Duration in ticks; 0 means end of pass |
| start | input | 1 | Begin (or restart) playback from entry 0 |
| cancel | input | 1 | Finish the current pass, then stop |
| reps | input | RW | Pass count, 0 = endless |
| car_period | input | CW | Carrier counter top value (period is car_period+1 cycles) |
| car_compare | input | CW | Carrier high while counter is below this |
| busy | output | 1 | Playback in progress |
| pulse_out | output | 1 | Mark/space pulse train |
| carrier_out | output | 1 | Carrier gated by mark phase |
| edge_stb | output | 1 | One-cycle strobe at the start of each entry |

## Verification
A bad duration counter or entry index shows on `pulse_out` within the entry where it occurs. A mark or space comes out too long or too short, or two levels run together, and the bench measures every segment of a playback against the table in cycles. A wrong end index or a wrong pass counter shows up as a wrong total `busy` length or a wrong number of `edge_stb` strobes, both seen when the run ends. For an endless playback this is at the first cancel. Carrier leakage into a space, or a stuck carrier compare, shows in the first mark or space affected, because the bench counts carrier-high cycles during marks and during spaces separately.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic {
    W_IDLE = 1'b0,
    W_RUN  = 1'b1
  } walk_st_e;
endpackage

// File: rtl/pseq_store.sv
module pseq_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] stop_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] slot_zero;
  logic [AW-1:0]    first_zero;

  // the last slot is never written and always reads zero
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && wr_addr != LAST) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = (rd_addr == LAST) ? '0 : mem[rd_addr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_zero
    if (g == DEPTH - 1) begin : g_term
      assign slot_zero[g] = 1'b1;
    end else begin : g_data
      assign slot_zero[g] = (mem[g] == '0);
    end
  end

  // lowest zero slot wins; an odd index drops the trailing mark
  always_comb begin
    first_zero = LAST;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (slot_zero[i]) first_zero = AW'(i);
    end
    stop_o = first_zero & ~AW'(1);
  end

  // R3
  stop_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_o[0]);
endmodule

// File: rtl/pseq_walker.sv
module pseq_walker
  import pseq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          start,
  input  logic          cancel,
  input  logic [RW-1:0] reps,
  input  logic [AW-1:0] stop_scan,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          pulse,
  output logic          stb
);
  walk_st_e      st;
  logic [AW-1:0] idx;
  logic [AW-1:0] stop_q;
  logic [DW-1:0] cnt;
  logic [RW-1:0] left;
  logic          stb_q;
  logic          running;
  logic [AW-1:0] idx_inc;
  logic          pass_end;
  logic          wrap;

  assign running  = (st == W_RUN);
  assign idx_inc  = idx + AW'(1);
  assign pass_end = (idx_inc == stop_q);
  assign wrap     = pass_end && (left != RW'(1));
  assign rd_addr  = (start || wrap) ? '0 : idx_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      idx    <= '0;
      stop_q <= '0;
      cnt    <= '0;
      left   <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (start) begin
        idx    <= '0;
        cnt    <= rd_data;
        left   <= reps;
        stop_q <= stop_scan;
        if (stop_scan != '0) begin
          st    <= W_RUN;
          stb_q <= 1'b1;
        end else begin
          st <= W_IDLE;
        end
      end else if (running) begin
        if (cancel) left <= RW'(1);
        if (tick_en) begin
          if (cnt != DW'(1)) begin
            cnt <= cnt - DW'(1);
          end else if (pass_end && left == RW'(1)) begin
            st <= W_IDLE;
          end else begin
            idx   <= wrap ? '0 : idx_inc;
            cnt   <= rd_data;
            stb_q <= 1'b1;
            if (wrap && !cancel && left != '0) left <= left - RW'(1);
          end
        end
      end
    end
  end

  assign busy  = running;
  assign pulse = running && !idx[0];
  assign stb   = stb_q;

  // R2
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt != '0));
  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (idx < stop_q));
  // R4
  forever_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && left == '0 && !start && !cancel) |=> running);
  // R8
  stb_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && (pulse != $past(pulse))) |-> stb_q);
endmodule

// File: rtl/pseq_carrier.sv
module pseq_carrier #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] compare,
  input  logic          mark,
  output logic          car_out
);
  logic [CW-1:0] ctr;
  logic          raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr   <= '0;
      raw_q <= 1'b0;
    end else begin
      ctr   <= (ctr >= period) ? '0 : ctr + CW'(1);
      raw_q <= (ctr < compare);
    end
  end

  assign car_out = raw_q & mark;

  // R6
  car_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr >= period) |=> (ctr == '0));
endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int RW    = 16,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  input  logic          cancel,
  input  logic [RW-1:0] reps,
  input  logic [CW-1:0] car_period,
  input  logic [CW-1:0] car_compare,
  output logic          busy,
  output logic          pulse_out,
  output logic          carrier_out,
  output logic          edge_stb
);
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] stop_idx;
  logic          wr_fire;

  assign wr_ready = !busy;
  assign wr_fire  = wr_valid && wr_ready;

  pseq_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .stop_o  (stop_idx)
  );

  pseq_walker #(.DW(DW), .AW(AW), .RW(RW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .start     (start),
    .cancel    (cancel),
    .reps      (reps),
    .stop_scan (stop_idx),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .pulse     (pulse_out),
    .stb       (edge_stb)
  );

  pseq_carrier #(.CW(CW)) u_car (
    .clk     (clk),
    .rst_n   (rst_n),
    .period  (car_period),
    .compare (car_compare),
    .mark    (pulse_out),
    .car_out (carrier_out)
  );

  // R1
  no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !start) |-> $stable(rd_data) || (rd_addr != $past(rd_addr)));
endmodule

// File: tb/sim_pulse_seq_top.sv
`timescale 1ns/1ps
module sim_pulse_seq_top;
  localparam int DW = 32, DEPTH = 16, AW = 4, RW = 16, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1;
  logic wr_valid = 1'b0, start = 1'b0, cancel = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [RW-1:0] reps = '0;
  logic [CW-1:0] car_period = '0, car_compare = '0;
  logic wr_ready, busy, pulse_out, carrier_out, edge_stb;

  pulse_seq_top #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .RW(RW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .cancel(cancel), .reps(reps), .car_period(car_period),
    .car_compare(car_compare), .busy(busy), .pulse_out(pulse_out),
    .carrier_out(carrier_out), .edge_stb(edge_stb)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int img [DEPTH];
  int seg_len [256];
  int eseg [256];
  int nseg, neseg, esum, first_lvl;
  int c_busy, c_stb, c_cmark, c_cspace, c_rdy;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_img();
    foreach (img[i]) img[i] = 0;
  endtask

  task automatic load_img();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_addr  = AW'(i);
      wr_data  = DW'(img[i]);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // expected segments: slot DEPTH-1 reads zero, odd end index rounds down
  task automatic build_exp(input int r);
    int stop;
    stop = DEPTH - 1;
    for (int i = DEPTH - 2; i >= 0; i--) if (img[i] == 0) stop = i;
    stop = stop & ~1;
    neseg = 0;
    esum  = 0;
    for (int p = 0; p < r; p++)
      for (int i = 0; i < stop; i++) begin
        eseg[neseg] = img[i];
        neseg++;
        esum += img[i];
      end
  endtask

  task automatic do_start(input int r);
    @(negedge clk);
    start = 1'b1;
    reps  = RW'(r);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic capture();
    int lvl;
    lvl = -1; nseg = 0; c_busy = 0; c_stb = 0; c_cmark = 0; c_cspace = 0; c_rdy = 0;
    first_lvl = -1;
    while (busy && c_busy < 4000) begin
      c_busy++;
      if (edge_stb) c_stb++;
      if (wr_ready) c_rdy++;
      if (carrier_out) begin
        if (pulse_out) c_cmark++;
        else c_cspace++;
      end
      if (first_lvl < 0) first_lvl = int'(pulse_out);
      if (int'(pulse_out) != lvl) begin
        if (nseg < 256) seg_len[nseg] = 0;
        nseg++;
        lvl = int'(pulse_out);
      end
      if (nseg <= 256) seg_len[nseg-1]++;
      @(negedge clk);
    end
  endtask

  task automatic cmp_run(input string req);
    int bad;
    bad = -1;
    chk(first_lvl == 1, {req, " first segment is a mark"}, first_lvl, 1);
    chk(nseg == neseg, {req, " segment count"}, nseg, neseg);
    for (int i = 0; i < neseg && i < nseg && i < 256; i++)
      if (bad < 0 && seg_len[i] != eseg[i]) bad = i;
    chk(bad < 0, {req, " segment length"}, (bad < 0) ? 0 : seg_len[bad],
        (bad < 0) ? 0 : eseg[bad]);
    chk(c_busy == esum, "R7 busy length", c_busy, esum);
    chk(c_stb == neseg, "R8 strobe count", c_stb, neseg);
    chk(c_rdy == 0, "R1 wr_ready low while busy", c_rdy, 0);
    chk(c_cspace == 0, "R6 carrier off in space", c_cspace, 0);
    chk(!pulse_out && !carrier_out, "R2 outputs low when idle",
        int'(pulse_out) + int'(carrier_out), 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R7 reset busy", int'(busy), 0);
    chk(pulse_out == 1'b0, "R2 reset pulse", int'(pulse_out), 0);
    chk(carrier_out == 1'b0, "R6 reset carrier", int'(carrier_out), 0);
    chk(edge_stb == 1'b0, "R8 reset strobe", int'(edge_stb), 0);
    chk(wr_ready == 1'b1, "R1 reset ready", int'(wr_ready), 1);
  endtask

  task automatic t_single();
    car_period = CW'(3); car_compare = CW'(2);
    clear_img(); img[0] = 8; img[1] = 3; img[2] = 12; img[3] = 5;
    load_img(); build_exp(1);
    do_start(1); capture();
    cmp_run("R2");
    chk(c_cmark == 10, "R6 carrier half duty in marks", c_cmark, 10);
  endtask

  task automatic t_odd();
    clear_img(); img[0] = 6; img[1] = 2; img[2] = 9;
    load_img(); build_exp(1);
    do_start(1); capture();
    cmp_run("R3");
  endtask

  task automatic t_repeat();
    clear_img(); img[0] = 4; img[1] = 2;
    load_img();
    @(negedge clk); cancel = 1'b1;
    @(negedge clk); cancel = 1'b0;
    build_exp(3);
    do_start(3); capture();
    cmp_run("R4/R5 idle cancel ignored");
  endtask

  task automatic t_forever_cancel();
    int n;
    clear_img(); img[0] = 4; img[1] = 4;
    load_img();
    do_start(0);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      if (busy) n++;
      @(negedge clk);
    end
    chk(busy == 1'b1, "R4 endless still busy", int'(busy), 1);
    chk(n == 100, "R4 no idle gap between passes", n, 100);
    cancel = 1'b1;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
      cancel = 1'b0;
    end
    cancel = 1'b0;
    chk(n == 104, "R5 cancel ends after current pass", n, 104);
  endtask

  task automatic t_empty();
    int hits;
    clear_img();
    load_img();
    do_start(1);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      if (busy || pulse_out) hits++;
      @(negedge clk);
    end
    chk(hits == 0, "R7 empty table stays idle", hits, 0);
    img[0] = 7;
    load_img();
    do_start(1);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      if (busy || pulse_out || edge_stb) hits++;
      @(negedge clk);
    end
    chk(hits == 0, "R3 lone mark dropped", hits, 0);
  endtask

  task automatic t_last_slot();
    foreach (img[i]) img[i] = 2;
    load_img();
    build_exp(1);
    chk(neseg == DEPTH - 2, "R1 last slot forced zero in model", neseg, DEPTH - 2);
    do_start(1); capture();
    cmp_run("R1 last slot write dropped");
  endtask

  task automatic t_restart();
    clear_img(); img[0] = 10; img[1] = 10;
    load_img();
    do_start(0);
    repeat (15) @(negedge clk);
    build_exp(1);
    do_start(1); capture();
    cmp_run("R9");
  endtask

  task automatic t_freeze();
    int n, bad;
    clear_img(); img[0] = 3; img[1] = 2;
    load_img();
    tick_en = 1'b0;
    do_start(1);
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      if (!busy || !pulse_out) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R10 frozen without tick", bad, 0);
    tick_en = 1'b1;
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == 5, "R10 resumes on ticks", n, 5);
  endtask

  task automatic t_carrier_modes();
    clear_img(); img[0] = 8; img[1] = 3;
    load_img();
    car_period = CW'(3); car_compare = CW'(9);
    build_exp(1);
    do_start(1); capture();
    chk(c_cmark == 8, "R6 compare above period full on", c_cmark, 8);
    chk(c_cspace == 0, "R6 full on still off in space", c_cspace, 0);
    car_compare = CW'(0);
    do_start(1); capture();
    chk(c_cmark == 0, "R6 compare zero off", c_cmark, 0);
    chk(c_busy == esum, "R7 busy length repeat", c_busy, esum);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_odd();
    t_repeat();
    t_forever_cancel();
    t_empty();
    t_last_slot();
    t_restart();
    t_freeze();
    t_carrier_modes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule